// File: doc/BRIEF.md
# Match Timer with Pulse-Width Capture

This block keeps one 8-bit up-counter and uses it in one of two ways. In timer mode the counter advances on each tick of the selected timebase. When the value it would take next equals a programmed match value, it returns to zero and raises a one-clock interrupt instead. This gives a periodic interrupt every N ticks. In pulse-width mode the counter again advances on timebase ticks, but each chosen edge of an external input stores the running count in a capture register, restarts the counter and raises the interrupt. This measures the time between successive edges.

The timebase is one of two tick enables, a fast one and a slow one, picked by a select bit. Both tick inputs are single-cycle enables in the block's clock domain. The external input is asynchronous and passes through a two-flop synchronizer before edge detection. A change of mode or of timebase clears the counter, so a new measurement or period always starts from zero.

Top module: `pulse_match_timer`

## Requirements
- R1: After reset, count, capture and irq are all 0.
- R2: The counter advances by one only on a cycle where the selected tick is high. rate_sel = 0 selects tick_fast and rate_sel = 1 selects tick_slow. The unselected tick has no effect.
- R3: In timer mode (pw_en = 0), a selected tick whose incremented value equals cmp_val sets count to 0 and raises irq on the next clock. A match value of N therefore gives one interrupt every N ticks, and cmp_val = 0 gives one every 256 ticks.
- R4: irq is high for exactly one clock per event.
- R5: In pulse-width mode (pw_en = 1), a selected input edge loads the current count into capture, sets count to 0 and raises irq.
- R6: edge_mode chooses the active input edge: 2'b00 rising only, 2'b01 falling only, 2'b10 or 2'b11 both. An edge that is not selected leaves count and capture unchanged and raises no irq.
- R7: In pulse-width mode the counter holds at 255 instead of wrapping.
- R8: A level change on sense_in applied between clock edges takes effect at the third following rising clock edge. The first two edges only move it through the synchronizer.
- R9: A change of pw_en or rate_sel clears count on the next clock without raising irq.
- R10: In pulse-width mode, an edge and a tick in the same cycle restart the counter at 0. The tick is not counted.
- R11: In timer mode, capture holds its value and input edges have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Fast timebase enable, one cycle per tick |
| tick_slow | input | 1 | Slow timebase enable, one cycle per tick |
| rate_sel | input | 1 | Timebase select: 0 fast, 1 slow |
| pw_en | input | 1 | 1 selects pulse-width mode, 0 selects timer mode |
| edge_mode | input | 2 | Active edge of sense_in (see R6) |
| cmp_val | input | 8 | Match value for timer mode |
| sense_in | input | 1 | Asynchronous measured input |
| count | output | 8 | Current counter value |
| capture | output | 8 | Count latched at the last selected edge |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
A corrupted counter shows on count in the clock after the tick that caused it. In timer mode it also shows as an interrupt that arrives early, late or not at all, within one match period. A bad synchronizer or edge selector appears as capture changing one clock too early or too late, or changing on an edge that was not selected. These faults are visible within three clocks of the input change. A stuck configuration tracker leaves a stale count after a mode or rate change, and that shows at the first sample after the change.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/pwt_tick_mux.sv
module pwt_tick_mux (
  input  logic tick_fast,
  input  logic tick_slow,
  input  logic rate_sel,
  output logic tick
);
  always_comb begin
    tick = rate_sel ? tick_slow : tick_fast;
  end
endmodule

// File: rtl/pwt_edge_detect.sv
module pwt_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] edge_mode,
  output logic       hit
);
  import pwt_pkg::*;

  localparam int TOP = STAGES - 1;

  logic [TOP:0] sync_q, sync_d;
  logic         last_q, last_d;
  logic         rise, fall;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[TOP-1:0], din};
    end else begin : g_single
      always_comb sync_d = din;
    end
  endgenerate

  always_comb begin
    last_d = sync_q[TOP];
    rise   = sync_q[TOP] & ~last_q;
    fall   = ~sync_q[TOP] & last_q;
    unique case (edge_sel_e'(edge_mode))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      default:   hit = rise | fall;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/pwt_counter.sv
module pwt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         hit,
  input  logic         pw_en,
  input  logic         rate_sel,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count,
  output logic [W-1:0] capture,
  output logic         irq
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] cnt_q, cnt_d, cap_q, cap_d, inc;
  logic         irq_q, irq_d;
  logic         pw_q, rate_q, cfg_chg;

  always_comb begin
    cfg_chg = (pw_en != pw_q) || (rate_sel != rate_q);
    inc     = cnt_q + ONE;
    cnt_d   = cnt_q;
    cap_d   = cap_q;
    irq_d   = 1'b0;
    if (cfg_chg) begin
      cnt_d = '0;
    end else if (pw_en) begin
      if (hit) begin
        cap_d = cnt_q;
        cnt_d = '0;
        irq_d = 1'b1;
      end else if (tick && (cnt_q != FULL)) begin
        cnt_d = inc;
      end
    end else if (tick) begin
      if (inc == cmp_val) begin
        cnt_d = '0;
        irq_d = 1'b1;
      end else begin
        cnt_d = inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      irq_q  <= 1'b0;
      pw_q   <= 1'b0;
      rate_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      irq_q  <= irq_d;
      pw_q   <= pw_en;
      rate_q <= rate_sel;
    end
  end

  assign count   = cnt_q;
  assign capture = cap_q;
  assign irq     = irq_q;

  assert_irq_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0));

  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pw_en && !tick && !cfg_chg) |=> ($stable(count) && !irq));

  assert_edge_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_en && hit && !cfg_chg) |=> (irq && count == '0));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_en && count == FULL && !hit && !cfg_chg) |=> (count == FULL));

  assert_cfg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (count == '0 && !irq));

  assert_capture_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pw_en |=> $stable(capture));
endmodule

// File: rtl/pulse_match_timer.sv
module pulse_match_timer #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             rate_sel,
  input  logic             pw_en,
  input  logic [1:0]       edge_mode,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             sense_in,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             irq
);
  logic tick_sel;
  logic edge_hit;

  pwt_tick_mux u_tick (
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .rate_sel  (rate_sel),
    .tick      (tick_sel)
  );

  pwt_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (sense_in),
    .edge_mode (edge_mode),
    .hit       (edge_hit)
  );

  pwt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_sel),
    .hit      (edge_hit),
    .pw_en    (pw_en),
    .rate_sel (rate_sel),
    .cmp_val  (cmp_val),
    .count    (count),
    .capture  (capture),
    .irq      (irq)
  );
endmodule

// File: tb/sim_pulse_match_timer.sv
module sim_pulse_match_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_fast = 1'b0, tick_slow = 1'b0, rate_sel = 1'b0, pw_en = 1'b0;
  logic [1:0] edge_mode = 2'b00;
  logic [7:0] cmp_val = 8'd0;
  logic       sense_in = 1'b0;
  logic [7:0] count, capture;
  logic       irq;

  int tests = 0, fails = 0;
  int irq_cnt = 0, width_err = 0;
  logic irq_last = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_match_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .rate_sel(rate_sel), .pw_en(pw_en), .edge_mode(edge_mode), .cmp_val(cmp_val),
    .sense_in(sense_in), .count(count), .capture(capture), .irq(irq)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (irq && irq_last) width_err++;
    irq_last = irq;
  end

  typedef struct packed {
    logic        rate;
    logic [7:0]  cmp;
    logic [15:0] nf;
    logic [15:0] ns;
    logic [7:0]  exp_cnt;
    logic [7:0]  exp_irq;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd5,   16'd7,   16'd3, 8'd2,   8'd1},
    '{1'b1, 8'd5,   16'd7,   16'd3, 8'd3,   8'd0},
    '{1'b0, 8'd1,   16'd4,   16'd0, 8'd0,   8'd4},
    '{1'b0, 8'd0,   16'd300, 16'd0, 8'd44,  8'd1},
    '{1'b1, 8'd3,   16'd0,   16'd9, 8'd0,   8'd3},
    '{1'b0, 8'd255, 16'd254, 16'd0, 8'd254, 8'd0},
    '{1'b0, 8'd255, 16'd255, 16'd0, 8'd0,   8'd1}
  };

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic r, input logic p, input logic [1:0] em, input logic [7:0] c);
    @(negedge clk);
    rst_n = 1'b0; rate_sel = r; pw_en = p; edge_mode = em; cmp_val = c;
    sense_in = 1'b0; tick_fast = 1'b0; tick_slow = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int nf, input int ns);
    for (int i = 0; i < nf; i++) begin
      @(negedge clk) tick_fast = 1'b1;
      @(negedge clk) tick_fast = 1'b0;
    end
    for (int i = 0; i < ns; i++) begin
      @(negedge clk) tick_slow = 1'b1;
      @(negedge clk) tick_slow = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    // R1 reset state
    do_reset(1'b0, 1'b0, 2'b00, 8'd0);
    check("R1 count", count, 0);
    check("R1 capture", capture, 0);
    check("R1 irq", irq, 0);

    // R2 / R3 timer vectors
    foreach (VECS[k]) begin
      do_reset(VECS[k].rate, 1'b0, 2'b00, VECS[k].cmp);
      base = irq_cnt;
      ticks(VECS[k].nf, VECS[k].ns);
      idle(1);
      check($sformatf("R2/R3 vec%0d count", k), count, VECS[k].exp_cnt);
      check($sformatf("R3 vec%0d irqs", k), irq_cnt - base, VECS[k].exp_irq);
    end

    // R9 config change clears
    do_reset(1'b0, 1'b0, 2'b00, 8'd0);
    ticks(3, 0);
    check("R9 pre count", count, 3);
    base = irq_cnt;
    rate_sel = 1'b1;
    idle(1);
    check("R9 rate change count", count, 0);
    ticks(0, 2);
    check("R9 slow count", count, 2);
    pw_en = 1'b1;
    idle(1);
    check("R9 mode change count", count, 0);
    check("R9 no irq", irq_cnt - base, 0);

    // R5 / R8 / R4 pulse-width rising
    do_reset(1'b0, 1'b1, 2'b00, 8'd0);
    ticks(10, 0);
    sense_in = 1'b1;
    idle(1);
    check("R8 edge1 count", count, 10);
    check("R8 edge1 irq", irq, 0);
    idle(1);
    check("R8 edge2 capture", capture, 0);
    check("R8 edge2 irq", irq, 0);
    idle(1);
    check("R5 capture", capture, 10);
    check("R5 count", count, 0);
    check("R5 irq", irq, 1);
    idle(1);
    check("R4 irq drop", irq, 0);

    // R6 edge selection
    ticks(4, 0);
    base = irq_cnt;
    sense_in = 1'b0;
    idle(4);
    check("R6 fall ignored capture", capture, 10);
    check("R6 fall ignored count", count, 4);
    check("R6 fall ignored irq", irq_cnt - base, 0);
    edge_mode = 2'b01;
    sense_in = 1'b1;
    idle(4);
    check("R6 rise ignored capture", capture, 10);
    check("R6 rise ignored count", count, 4);
    sense_in = 1'b0;
    idle(3);
    check("R6 fall capture", capture, 4);
    check("R6 fall count", count, 0);
    edge_mode = 2'b10;
    ticks(7, 0);
    sense_in = 1'b1;
    idle(3);
    check("R6 both rise capture", capture, 7);
    ticks(2, 0);
    sense_in = 1'b0;
    idle(3);
    check("R6 both fall capture", capture, 2);

    // R10 edge and tick together
    ticks(5, 0);
    sense_in = 1'b1;
    idle(2);
    tick_fast = 1'b1;
    idle(1);
    tick_fast = 1'b0;
    check("R10 capture", capture, 5);
    check("R10 count", count, 0);
    idle(1);
    check("R10 count hold", count, 0);

    // R7 saturation
    ticks(300, 0);
    check("R7 saturate", count, 255);
    sense_in = 1'b0;
    idle(3);
    check("R7 capture full", capture, 255);

    // R11 timer mode ignores input
    pw_en = 1'b0;
    cmp_val = 8'd0;
    idle(1);
    base = irq_cnt;
    sense_in = 1'b1;
    idle(4);
    sense_in = 1'b0;
    idle(4);
    check("R11 capture hold", capture, 255);
    check("R11 count", count, 0);
    check("R11 no irq", irq_cnt - base, 0);

    check("R4 irq width", width_err, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule